// File: doc/BRIEF.md
# Event Timer with Comparator Channel

The block holds one free-running 64-bit main counter and one comparator channel that raises an interrupt pulse when the counter reaches a programmed value. Software reaches four registers through a plain read/write port, with 64-bit or 32-bit accesses. The register index sits in `bus_addr[2:1]`: 0 is the info/control register, 1 the main counter, 2 the channel configuration, 3 the comparator. For a 32-bit access (`bus_wide`=0), `bus_addr[0]` picks the upper half when 1 and the lower half when 0. Reads are combinational. Writes take effect at the clock edge.

The channel runs in one-shot or periodic mode. Periodic mode adds a stored period to the compare value on each match. The channel also has a 32-bit mode, and that mode affects the shared counter too: carries stop at bit 31, and the upper half of the counter is held at zero. A set-value arming bit lets two consecutive comparator writes load first the compare value and then the period.

Top module: `evt_timer`

## Requirements
- R1: After reset the info register reads 0x1 (bit 0 = counter supports 64 bits), the configuration register reads 0x20 (bit 5 = channel supports 64-bit mode), the counter reads 0 and `irq` is low.
- R2: A write to the counter register is accepted only while the run bit (info bit 4) is 0. While it is 1 the write is ignored. 32-bit writes replace only the addressed half.
- R3: While the run bit is 1, each cycle with `tick` high adds one to the counter. With 32-bit mode off, the carry reaches all 64 bits. While the run bit is 0 the counter holds.
- R4: While the 32-bit mode bit (configuration bit 3) is 1, the counter wraps from 0xFFFFFFFF to 0 with no carry into bits 63:32, and its upper half reads 0.
- R5: Writing configuration bit 2 (set-value) as 1 arms a sequence. The next comparator write loads the compare value, and the write after it loads the period. Bit 2 reads 1 until the sequence completes.
- R6: Once the second comparator write of the sequence completes, configuration bit 2 reads 0.
- R7: `irq` is high for exactly one cycle: the cycle in which the counter first holds, after a tick, a value equal to the comparator over the active width.
- R8: With the periodic bit (configuration bit 1) set, each match adds the period to the compare value. The sum wraps at 32 bits in 32-bit mode and at 64 bits otherwise.
- R9: With the periodic bit clear (one-shot), a match leaves the compare value unchanged. No further pulse occurs until the counter reaches that value again.
- R10: While the enable bit (configuration bit 0) is 0, no `irq` pulse and no periodic reload occur.
- R11: In 32-bit mode the upper 32 bits of the comparator take no part in matching and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable pulse for the main counter |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register index in bits 2:1, half select in bit 0 |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_wdata | input | 64 | Write data; a 32-bit write uses bits 31:0 |
| rd_data | output | 64 | Combinational read data for `bus_addr` |
| irq | output | 1 | One-cycle match pulse |

## Verification
The bench walks the counter across the 32-bit boundary twice. In 64-bit mode the carry must reach bit 32. In 32-bit mode it must not, so a design that lets the carry through reads 0x1_00000000 where 0 is expected. It issues counter writes while the counter runs, which a design that forgets the run gate would accept. It steps through the set-value sequence one write at a time. A design that sends the first write to the period, or never clears the arming bit, shows a wrong compare value or a stale bit 2. It also sends a periodic reload past 0xFFFFFFFF in 32-bit mode, fires a one-shot, and places garbage in the upper comparator half, so a carry into the upper half or an upper-half compare turns up as a wrong readback or a missing pulse.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int unsigned CNT_W  = 64;
    localparam int unsigned HALF_W = CNT_W / 2;

    // register index carried in bus_addr[2:1]
    typedef enum logic [1:0] {
        REG_INFO = 2'd0,
        REG_CNT  = 2'd1,
        REG_CFG  = 2'd2,
        REG_CMP  = 2'd3
    } reg_e;

    // progress of the set-value write sequence
    typedef enum logic [1:0] {
        SV_IDLE   = 2'd0,
        SV_VALUE  = 2'd1,
        SV_PERIOD = 2'd2
    } setval_e;

    // bit positions shared by RTL and software
    localparam int unsigned INFO_CAP64_BIT = 0;
    localparam int unsigned INFO_RUN_BIT   = 4;
    localparam int unsigned CFG_EN_BIT     = 0;
    localparam int unsigned CFG_PER_BIT    = 1;
    localparam int unsigned CFG_SETV_BIT   = 2;
    localparam int unsigned CFG_M32_BIT    = 3;
    localparam int unsigned CFG_CAP64_BIT  = 5;

    typedef struct packed {
        logic m32;
        logic periodic;
        logic en;
    } ch_cfg_t;

    typedef struct packed {
        logic              wr;
        reg_e              idx;
        logic              hi;
        logic              wide;
        logic [CNT_W-1:0]  data;
    } bus_req_t;

    // merge a 64-bit or 32-bit write into an existing 64-bit value
    function automatic logic [CNT_W-1:0] merge_wr(
        input logic [CNT_W-1:0] old,
        input logic [CNT_W-1:0] wdata,
        input logic             wide,
        input logic             hi
    );
        logic [CNT_W-1:0] res;
        res = old;
        if (wide)
            res = wdata;
        else if (hi)
            res[CNT_W-1:HALF_W] = wdata[HALF_W-1:0];
        else
            res[HALF_W-1:0] = wdata[HALF_W-1:0];
        return res;
    endfunction

    // comparison over the active width
    function automatic logic width_eq(
        input logic [CNT_W-1:0] a,
        input logic [CNT_W-1:0] b,
        input logic             m32
    );
        if (m32)
            return a[HALF_W-1:0] == b[HALF_W-1:0];
        return a == b;
    endfunction

    // hide the upper half in 32-bit mode
    function automatic logic [CNT_W-1:0] mask_hi(
        input logic [CNT_W-1:0] v,
        input logic             m32
    );
        return m32 ? {{HALF_W{1'b0}}, v[HALF_W-1:0]} : v;
    endfunction

endpackage

// File: rtl/evt_counter.sv
module evt_counter
    import evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             m32,
    input  logic             wr,
    input  logic             wide,
    input  logic             hi,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_inc,
    output logic             adv
);

    logic [CNT_W-1:0] cnt_nxt;
    logic [HALF_W-1:0] lo_inc;

    assign lo_inc  = cnt_q[HALF_W-1:0] + 1'b1;
    assign cnt_inc = m32 ? {{HALF_W{1'b0}}, lo_inc} : cnt_q + 1'b1;
    assign adv     = run & tick;

    always_comb begin
        cnt_nxt = cnt_q;
        if (wr && !run)
            cnt_nxt = merge_wr(cnt_q, wdata, wide, hi);
        else if (adv)
            cnt_nxt = cnt_inc;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= mask_hi(cnt_nxt, m32);
    end

endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
#(
    parameter bit CH64_CAP = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cmp_wr,
    input  logic             wide,
    input  logic             hi,
    input  logic [CNT_W-1:0] wdata,
    input  logic             adv,
    input  logic [CNT_W-1:0] cnt_inc,
    output logic             ch_en,
    output logic             m32,
    output logic             setval_pend,
    output logic             pend_period,
    output logic [CNT_W-1:0] cfg_rd,
    output logic [CNT_W-1:0] cmp_rd,
    output logic             irq
);

    ch_cfg_t          cfg_q;
    setval_e          sv_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] per_q;
    logic             hit;
    logic             low_wr;
    logic [CNT_W-1:0] reload;

    generate
        if (CH64_CAP) begin : g_cap64
            assign m32 = cfg_q.m32;
        end else begin : g_cap32
            assign m32 = 1'b1;
        end
    endgenerate

    assign ch_en       = cfg_q.en;
    assign setval_pend = (sv_q != SV_IDLE);
    assign pend_period = (sv_q == SV_PERIOD);
    assign low_wr      = wide | ~hi;
    assign hit         = cfg_q.en & adv & width_eq(cnt_inc, cmp_q, m32);
    assign reload      = m32 ? {cmp_q[CNT_W-1:HALF_W], cmp_q[HALF_W-1:0] + per_q[HALF_W-1:0]}
                             : cmp_q + per_q;

    always_comb begin
        cfg_rd = '0;
        cfg_rd[CFG_EN_BIT]    = cfg_q.en;
        cfg_rd[CFG_PER_BIT]   = cfg_q.periodic;
        cfg_rd[CFG_SETV_BIT]  = setval_pend;
        cfg_rd[CFG_M32_BIT]   = m32;
        cfg_rd[CFG_CAP64_BIT] = CH64_CAP;
    end

    assign cmp_rd = mask_hi(cmp_q, m32);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            sv_q  <= SV_IDLE;
            cmp_q <= '1;
            per_q <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= hit;
            if (cfg_wr && low_wr) begin
                cfg_q.en       <= wdata[CFG_EN_BIT];
                cfg_q.periodic <= wdata[CFG_PER_BIT];
                cfg_q.m32      <= wdata[CFG_M32_BIT];
                if (wdata[CFG_SETV_BIT])
                    sv_q <= SV_VALUE;
            end
            if (cmp_wr) begin
                if (sv_q == SV_PERIOD) begin
                    per_q <= merge_wr(per_q, wdata, wide, hi);
                    sv_q  <= SV_IDLE;
                end else begin
                    cmp_q <= merge_wr(cmp_q, wdata, wide, hi);
                    if (sv_q == SV_VALUE)
                        sv_q <= SV_PERIOD;
                end
            end else if (hit && cfg_q.periodic) begin
                cmp_q <= reload;
            end
        end
    end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_pkg::*;
#(
    parameter bit CNT64_CAP = 1'b1,
    parameter bit CH64_CAP  = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wide,
    input  logic [63:0] bus_wdata,
    output logic [63:0] rd_data,
    output logic        irq
);

    bus_req_t         req;
    logic             run_q;
    logic             cnt_wr;
    logic             cfg_wr;
    logic             cmp_wr;
    logic             m32;
    logic             ch_en;
    logic             setval_pend;
    logic             pend_period;
    logic             adv;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cfg_rd;
    logic [CNT_W-1:0] cmp_rd;
    logic [CNT_W-1:0] info_rd;
    logic [CNT_W-1:0] sel_rd;

    assign req.wr   = bus_wr;
    assign req.idx  = reg_e'(bus_addr[2:1]);
    assign req.hi   = bus_addr[0];
    assign req.wide = bus_wide;
    assign req.data = bus_wdata;

    assign cnt_wr = req.wr && (req.idx == REG_CNT);
    assign cfg_wr = req.wr && (req.idx == REG_CFG);
    assign cmp_wr = req.wr && (req.idx == REG_CMP);

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= 1'b0;
        else if (req.wr && req.idx == REG_INFO && (req.wide || !req.hi))
            run_q <= req.data[INFO_RUN_BIT];
    end

    evt_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .tick    (tick),
        .m32     (m32),
        .wr      (cnt_wr),
        .wide    (req.wide),
        .hi      (req.hi),
        .wdata   (req.data),
        .cnt_q   (cnt_q),
        .cnt_inc (cnt_inc),
        .adv     (adv)
    );

    evt_channel #(.CH64_CAP(CH64_CAP)) u_ch (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .cmp_wr      (cmp_wr),
        .wide        (req.wide),
        .hi          (req.hi),
        .wdata       (req.data),
        .adv         (adv),
        .cnt_inc     (cnt_inc),
        .ch_en       (ch_en),
        .m32         (m32),
        .setval_pend (setval_pend),
        .pend_period (pend_period),
        .cfg_rd      (cfg_rd),
        .cmp_rd      (cmp_rd),
        .irq         (irq)
    );

    always_comb begin
        info_rd = '0;
        info_rd[INFO_CAP64_BIT] = CNT64_CAP;
        info_rd[INFO_RUN_BIT]   = run_q;
    end

    always_comb begin
        unique case (req.idx)
            REG_INFO: sel_rd = info_rd;
            REG_CNT:  sel_rd = mask_hi(cnt_q, m32);
            REG_CFG:  sel_rd = cfg_rd;
            default:  sel_rd = cmp_rd;
        endcase
        if (req.wide)
            rd_data = sel_rd;
        else if (req.hi)
            rd_data = {{HALF_W{1'b0}}, sel_rd[CNT_W-1:HALF_W]};
        else
            rd_data = {{HALF_W{1'b0}}, sel_rd[HALF_W-1:0]};
    end

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        irq,
    input logic        run,
    input logic        m32,
    input logic        ch_en,
    input logic [63:0] cnt,
    input logic        cnt_wr,
    input logic        cfg_wr,
    input logic        cmp_wr,
    input logic        pend_period,
    input logic        setval_pend
);

    // R3: one step per tick in 64-bit mode
    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !m32) |=> (cnt == $past(cnt) + 64'd1));

    // R2 / R3: counter holds when no tick and no accepted write
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!m32 && !(run && tick) && !(cnt_wr && !run)) |=> $stable(cnt));

    // R4: upper half stays zero in 32-bit mode
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        m32 |=> (cnt[63:32] == 32'd0));

    // R7: a pulse follows a tick
    a_r7_irq_after_tick: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(tick) && $past(run));

    // R10: a pulse needs the channel enabled
    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(ch_en));

    // R6: arming clears after the period write
    a_r6_setval_clears: assert property (@(posedge clk) disable iff (rst)
        (pend_period && cmp_wr && !cfg_wr) |=> !setval_pend);

endmodule

bind evt_timer evt_timer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .irq         (irq),
    .run         (run_q),
    .m32         (m32),
    .ch_en       (ch_en),
    .cnt         (cnt_q),
    .cnt_wr      (cnt_wr),
    .cfg_wr      (cfg_wr),
    .cmp_wr      (cmp_wr),
    .pend_period (pend_period),
    .setval_pend (setval_pend)
);

// File: tb/evt_timer_test.sv
module evt_timer_test;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;

    localparam logic [2:0] A_INFO = 3'd0;
    localparam logic [2:0] A_CNT  = 3'd2;
    localparam logic [2:0] A_CFG  = 3'd4;
    localparam logic [2:0] A_CMP  = 3'd6;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  addr;
        logic        wide;
        logic [63:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{OP_RD, A_INFO, 1'b1, 64'h1,                  8'd1},  // R1
        '{OP_RD, A_CFG,  1'b1, 64'h20,                 8'd1},  // R1
        '{OP_WR, A_CNT,  1'b1, 64'h1_FFFF_FFFE,        8'd2},
        '{OP_RD, A_CNT,  1'b1, 64'h1_FFFF_FFFE,        8'd2},  // R2
        '{OP_WR, A_INFO, 1'b1, 64'h10,                 8'd3},
        '{OP_TK, A_INFO, 1'b1, 64'd3,                  8'd3},
        '{OP_RD, A_CNT,  1'b1, 64'h2_0000_0001,        8'd3},  // R3 carry
        '{OP_WR, A_CNT,  1'b1, 64'h0,                  8'd2},
        '{OP_RD, A_CNT,  1'b1, 64'h2_0000_0001,        8'd2},  // R2 ignored
        '{OP_WR, A_INFO, 1'b1, 64'h0,                  8'd3},
        '{OP_TK, A_INFO, 1'b1, 64'd2,                  8'd3},
        '{OP_RD, A_CNT,  1'b1, 64'h2_0000_0001,        8'd3},  // R3 hold
        '{OP_WR, A_CFG,  1'b1, 64'h8,                  8'd4},
        '{OP_RD, A_CNT,  1'b1, 64'h1,                  8'd4},  // R4 upper cleared
        '{OP_WR, A_CNT,  1'b0, 64'hFFFF_FFFF,          8'd2},
        '{OP_WR, A_INFO, 1'b1, 64'h10,                 8'd4},
        '{OP_TK, A_INFO, 1'b1, 64'd1,                  8'd4},
        '{OP_RD, A_CNT,  1'b1, 64'h0,                  8'd4},  // R4 no carry
        '{OP_RD, 3'd3,   1'b0, 64'h0,                  8'd4},  // R4 upper half
        '{OP_RD, A_CFG,  1'b1, 64'h28,                 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wide = 1'b1;
    logic [63:0] bus_wdata = '0;
    logic [63:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evt_timer uut (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wide  (bus_wide),
        .bus_wdata (bus_wdata),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic w, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wide = w; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic w, input logic [63:0] exp, input string tag);
        @(negedge clk);
        @(negedge clk);
        bus_addr = a; bus_wide = w;
        #1;
        check(tag, rd_data, exp);
    endtask

    // one tick; irq sampled in the cycle the counter takes the new value
    task automatic tk(input logic exp_irq, input string tag);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check(tag, {63'd0, irq}, {63'd0, exp_irq});
    endtask

    task automatic tk_quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset irq", {63'd0, irq}, 64'd0);
        rd(A_CNT, 1'b1, 64'd0, "R1 reset counter");

        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                OP_WR: wr(TBL[i].addr, TBL[i].wide, TBL[i].data);
                OP_TK: tk_quiet(int'(TBL[i].data));
                default: rd(TBL[i].addr, TBL[i].wide, TBL[i].data,
                            $sformatf("R%0d table step %0d", TBL[i].req, i));
            endcase
        end

        // R5 / R6: set-value sequence, counter now 0, running stopped
        wr(A_INFO, 1'b1, 64'h0);
        wr(A_CFG, 1'b1, 64'h7);
        rd(A_CFG, 1'b1, 64'h27, "R5 armed");
        wr(A_CMP, 1'b1, 64'd5);
        rd(A_CFG, 1'b1, 64'h27, "R5 still armed after value");
        wr(A_CMP, 1'b1, 64'd3);
        rd(A_CFG, 1'b1, 64'h23, "R6 cleared after period");
        rd(A_CMP, 1'b1, 64'd5, "R5 value kept");

        // R7 / R8: periodic pulses at 5 and 8
        wr(A_INFO, 1'b1, 64'h10);
        for (int i = 1; i <= 5; i++) tk(i == 5, "R7 first periodic hit");
        rd(A_CMP, 1'b1, 64'd8, "R8 reload");
        for (int i = 1; i <= 3; i++) tk(i == 3, "R7 second periodic hit");
        rd(A_CMP, 1'b1, 64'd11, "R8 second reload");

        // R9: one-shot at 11
        wr(A_CFG, 1'b1, 64'h1);
        for (int i = 1; i <= 3; i++) tk(i == 3, "R9 one-shot hit");
        for (int i = 1; i <= 3; i++) tk(1'b0, "R9 no repeat");
        rd(A_CMP, 1'b1, 64'd11, "R9 compare unchanged");

        // R10: disabled channel, counter at 14
        wr(A_CFG, 1'b1, 64'h0);
        wr(A_CMP, 1'b1, 64'd16);
        for (int i = 1; i <= 2; i++) tk(1'b0, "R10 no pulse when disabled");

        // R11: upper comparator bits ignored in 32-bit mode, counter at 16
        wr(A_CFG, 1'b1, 64'h9);
        wr(A_CMP, 1'b1, 64'hABCD_0000_0000_0014);
        rd(A_CMP, 1'b1, 64'h14, "R11 upper reads zero");
        for (int i = 1; i <= 4; i++) tk(i == 4, "R11 match on low half");

        // R8: periodic reload wraps at 32 bits
        wr(A_INFO, 1'b1, 64'h0);
        wr(A_CNT, 1'b1, 64'hFFFF_FFEF);
        wr(A_CFG, 1'b1, 64'hF);
        wr(A_CMP, 1'b1, 64'hFFFF_FFF0);
        wr(A_CMP, 1'b1, 64'h20);
        wr(A_INFO, 1'b1, 64'h10);
        tk(1'b1, "R8 hit before wrap");
        rd(A_CMP, 1'b1, 64'h10, "R8 reload wraps at 32 bits");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule